// File: doc/BRIEF.md
# Zero-Turnaround Pipelined Synchronous SRAM

This block is a cycle-accurate, synthesizable model of a synchronous SRAM built so that the shared data bus never needs an idle cycle when it changes direction. A command is made of an address, a read/write flag, byte-lane write enables and a load/advance flag. The command is sampled on one rising clock edge. Its data moves exactly two enabled edges later. For a write, the data is sampled at that edge. For a read, the data is presented just after it. Because reads and writes share the same latency, they can be issued back to back in any mix.

The word is 36 bits, made of four 9-bit lanes, and the depth is a parameter. An on-chip four-beat burst generator steps through addresses in either linear or interleaved order, starting from a single loaded address. The other controls are:

- **Clock enable.** An active-low clock enable freezes every register in the block.
- **Chip enables.** Three chip enables let several devices share a bus.
- **Output enable.** An asynchronous output enable gates the bus drive.

The bidirectional bus is split into a data-in port, a data-out port and a drive-enable flag. The pads themselves are not part of this block.

Top module: `zbt_sram`

## Requirements
- R1: A load command (adv_ld low, all three enables active, cken_n low) is sampled at rising edge N. Its data moves at the second enabled edge after N. Write data on wdata is sampled at that edge. Read data appears on rdata, with rdrive high, just after it.
- R2: Reads and writes may follow each other on consecutive cycles in any order with no idle cycle. A read issued on the cycle right after a write to the same address returns the new data.
- R3: Word bits [9i+8:9i] form lane i, for i = 0 to 3. A write stores lane i only when bw_n[i] is low at the command edge. All other lanes keep their old contents.
- R4: While cken_n is high, every synchronous input is ignored and all internal state holds, including rdata and rdrive. A command in flight resumes when cken_n returns low.
- R5: The three enables are active when sel1_n is low, sel2 is high and sel3_n is low. If adv_ld is low and any enable is inactive, no operation starts and any running burst ends. Operations already in the pipeline still complete.
- R6: rdrive goes low two enabled edges after a deselect or a write command, with no bus cycle driven for either.
- R7: When oe_n is high, rdrive is low at once, without a clock edge. It returns as soon as oe_n goes low again.
- R8: While a burst is active, adv_ld high issues the next operation, of the same kind as the load. rw, addr and the chip enables are ignored during an advance. Address bits above bit 1 stay equal to the loaded address, and the low two bits follow the burst order:
  - For step k, with k counting mod 4, linear order (lin_order = 1 at the load) gives (base + k) mod 4.
  - Interleaved order (lin_order = 0 at the load) gives base XOR k.
  - The order is captured at the load.
  - After four beats the sequence wraps.
- R9: adv_ld high with no active burst starts no operation.
- R10: After reset the pipeline is empty, no burst is active, rdrive is low and rdata is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| cken_n | input | 1 | Clock enable, active low; high freezes the block |
| adv_ld | input | 1 | Low loads a new address, high advances the burst |
| rw | input | 1 | 1 = read, 0 = write (sampled at a load) |
| sel1_n | input | 1 | Chip enable, active low |
| sel2 | input | 1 | Chip enable, active high |
| sel3_n | input | 1 | Chip enable, active low |
| bw_n | input | 4 | Per-lane write enables, active low |
| addr | input | AW | Word address, AW = clog2(DEPTH) |
| lin_order | input | 1 | Burst order: 1 linear, 0 interleaved |
| oe_n | input | 1 | Asynchronous output enable, active low |
| wdata | input | 36 | Write data, sampled two edges after its command |
| rdata | output | 36 | Registered read data |
| rdrive | output | 1 | Bus drive enable for rdata |

## Verification
Every result in this block is due a fixed number of enabled edges after its command. Read data and a falling rdrive are due two edges after the command edge. Write data must be presented before that same second edge. The oe_n gating takes effect with no edge at all.

The bench drives inputs and samples outputs on falling edges. A command driven at falling edge j is therefore checked at falling edge j+3, and the bench keeps small delay lines for write data and for expected read results. The frozen-clock test steps edge by edge and counts only the edges where cken_n is low. The output-enable test samples one nanosecond after toggling oe_n, inside a single clock phase.

// File: rtl/zbt_pkg.sv
package zbt_pkg;
  localparam int LANES     = 4;
  localparam int LANE_W    = 9;
  localparam int WORD_W    = LANES * LANE_W;
  localparam int BURST_LEN = 4;
  localparam int BCW       = $clog2(BURST_LEN);

  // One pipeline slot: valid, direction and per-lane write strobes
  typedef struct packed {
    logic             vld;
    logic             rd;
    logic [LANES-1:0] wen;
  } op_t;

  // Low address bits for beat 'step' of a burst starting at 'base'
  function automatic logic [BCW-1:0] burst_idx(input logic [BCW-1:0] base,
                                               input logic [BCW-1:0] step,
                                               input logic           linear);
    return linear ? (base + step) : (base ^ step);
  endfunction
endpackage

// File: rtl/zbt_burst.sv
module zbt_burst import zbt_pkg::*; #(
  parameter int AW = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ce,
  input  logic             adv_ld,
  input  logic             rw,
  input  logic             sel_ok,
  input  logic [LANES-1:0] bw_n,
  input  logic [AW-1:0]    addr,
  input  logic             lin_order,
  output op_t              iss_op,
  output logic [AW-1:0]    iss_addr
);
  logic           act_q;
  logic           rd_q;
  logic           lin_q;
  logic [AW-1:0]  base_q;
  logic [BCW-1:0] step_q;
  logic [BCW-1:0] step_nxt;
  logic           start;
  logic           cont;
  logic           is_rd;

  assign start    = !adv_ld && sel_ok;
  assign cont     = adv_ld && act_q;
  assign is_rd    = start ? rw : rd_q;
  assign step_nxt = step_q + 1'b1;

  always_comb begin
    iss_op.vld = start || cont;
    iss_op.rd  = is_rd;
    iss_op.wen = (start || cont) && !is_rd ? ~bw_n : '0;
    if (start)
      iss_addr = addr;
    else
      iss_addr = {base_q[AW-1:BCW], burst_idx(base_q[BCW-1:0], step_nxt, lin_q)};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      act_q  <= 1'b0;
      rd_q   <= 1'b0;
      lin_q  <= 1'b0;
      base_q <= '0;
      step_q <= '0;
    end else if (ce) begin
      if (!adv_ld) begin
        act_q  <= sel_ok;
        rd_q   <= rw;
        lin_q  <= lin_order;
        base_q <= addr;
        step_q <= '0;
      end else if (act_q) begin
        step_q <= step_nxt;
      end
    end
  end

  a_r5_deselect_ends_burst: assert property (@(posedge clk) disable iff (rst)
    (ce && !adv_ld && !sel_ok) |=> !act_q);
  a_r8_step_wraps: assert property (@(posedge clk) disable iff (rst)
    (ce && adv_ld && act_q) |=> (step_q == $past(step_q) + 1'b1));
  a_r4_burst_frozen: assert property (@(posedge clk) disable iff (rst)
    !ce |=> ($stable(step_q) && $stable(act_q) && $stable(base_q)));
endmodule

// File: rtl/zbt_pipe.sv
module zbt_pipe import zbt_pkg::*; #(
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ce,
  input  op_t           in_op,
  input  logic [AW-1:0] in_addr,
  output op_t           out_op,
  output logic [AW-1:0] out_addr
);
  op_t           op_s1, op_s2;
  logic [AW-1:0] ad_s1, ad_s2;

  always_ff @(posedge clk) begin
    if (rst) begin
      op_s1 <= '0;
      op_s2 <= '0;
      ad_s1 <= '0;
      ad_s2 <= '0;
    end else if (ce) begin
      op_s1 <= in_op;
      ad_s1 <= in_addr;
      op_s2 <= op_s1;
      ad_s2 <= ad_s1;
    end
  end

  assign out_op   = op_s2;
  assign out_addr = ad_s2;

  a_r1_stage_advance: assert property (@(posedge clk) disable iff (rst)
    ce |=> (op_s2 == $past(op_s1)));
  a_r4_stage_hold: assert property (@(posedge clk) disable iff (rst)
    !ce |=> ($stable(op_s1) && $stable(op_s2)));
  a_r3_read_no_strobe: assert property (@(posedge clk) disable iff (rst)
    op_s2.rd |-> (op_s2.wen == '0));
endmodule

// File: rtl/zbt_array.sv
module zbt_array import zbt_pkg::*; #(
  parameter int DEPTH = 256,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ce,
  input  op_t               op,
  input  logic [AW-1:0]     addr,
  input  logic [WORD_W-1:0] wdata,
  output logic [WORD_W-1:0] rdata_q,
  output logic              drive_q
);
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] mem [DEPTH];
    logic [LANE_W-1:0] lane_rd;

    always_ff @(posedge clk) begin
      if (ce && op.vld && op.wen[g])
        mem[addr] <= wdata[g*LANE_W +: LANE_W];
    end

    always_ff @(posedge clk) begin
      if (rst)
        lane_rd <= '0;
      else if (ce && op.vld && op.rd)
        lane_rd <= mem[addr];
    end

    assign rdata_q[g*LANE_W +: LANE_W] = lane_rd;
  end

  always_ff @(posedge clk) begin
    if (rst)
      drive_q <= 1'b0;
    else if (ce)
      drive_q <= op.vld && op.rd;
  end

  a_r6_write_drops_drive: assert property (@(posedge clk) disable iff (rst)
    (ce && op.vld && !op.rd) |=> !drive_q);
  a_r4_output_hold: assert property (@(posedge clk) disable iff (rst)
    !ce |=> ($stable(drive_q) && $stable(rdata_q)));
endmodule

// File: rtl/zbt_sram.sv
module zbt_sram import zbt_pkg::*; #(
  parameter  int DEPTH = 256,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cken_n,
  input  logic              adv_ld,
  input  logic              rw,
  input  logic              sel1_n,
  input  logic              sel2,
  input  logic              sel3_n,
  input  logic [LANES-1:0]  bw_n,
  input  logic [AW-1:0]     addr,
  input  logic              lin_order,
  input  logic              oe_n,
  input  logic [WORD_W-1:0] wdata,
  output logic [WORD_W-1:0] rdata,
  output logic              rdrive
);
  logic          ce;
  logic          sel_ok;
  op_t           iss_op, st2_op;
  logic [AW-1:0] iss_addr, st2_addr;
  logic          drv_q;

  assign ce     = !cken_n;
  assign sel_ok = !sel1_n && sel2 && !sel3_n;

  zbt_burst #(.AW(AW)) u_burst (
    .clk(clk), .rst(rst), .ce(ce), .adv_ld(adv_ld), .rw(rw), .sel_ok(sel_ok),
    .bw_n(bw_n), .addr(addr), .lin_order(lin_order),
    .iss_op(iss_op), .iss_addr(iss_addr)
  );

  zbt_pipe #(.AW(AW)) u_pipe (
    .clk(clk), .rst(rst), .ce(ce), .in_op(iss_op), .in_addr(iss_addr),
    .out_op(st2_op), .out_addr(st2_addr)
  );

  zbt_array #(.DEPTH(DEPTH), .AW(AW)) u_array (
    .clk(clk), .rst(rst), .ce(ce), .op(st2_op), .addr(st2_addr),
    .wdata(wdata), .rdata_q(rdata), .drive_q(drv_q)
  );

  assign rdrive = drv_q && !oe_n;

  a_r6_deselect_releases: assert property (@(posedge clk) disable iff (rst)
    (!cken_n && !adv_ld && !sel_ok) ##1 !cken_n ##1 !cken_n |=> !rdrive);
  a_r6_write_releases: assert property (@(posedge clk) disable iff (rst)
    (!cken_n && !adv_ld && sel_ok && !rw) ##1 !cken_n ##1 !cken_n |=> !rdrive);
  a_r1_read_drives: assert property (@(posedge clk) disable iff (rst)
    (!cken_n && !adv_ld && sel_ok && rw) ##1 !cken_n ##1 !cken_n |=> (rdrive || oe_n));
endmodule

// File: tb/zbt_sram_test.sv
module zbt_sram_test;
  localparam int DEPTH = 256;
  localparam int AW    = 8;

  logic        clk = 1'b0;
  logic        rst;
  logic        cken_n, adv_ld, rw, sel1_n, sel2, sel3_n, lin_order, oe_n;
  logic [3:0]  bw_n;
  logic [AW-1:0] addr;
  logic [35:0] wdata, rdata;
  logic        rdrive;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  // delay lines: write data and expected results of the last two commands
  logic [35:0] wd_p [2];
  logic        xr_p [2];
  logic [35:0] xd_p [2];
  string       tg_p [2];

  localparam logic [35:0] D1 = 36'h123456789;
  localparam logic [35:0] D2 = 36'h9ABCDEF01;
  localparam logic [35:0] D3 = 36'h0F0F0F0F0;
  localparam logic [35:0] P7 = 36'h876543210;
  localparam logic [35:0] N7 = 36'hFEDCBA987;

  always #2.5 clk = ~clk;

  zbt_sram #(.DEPTH(DEPTH)) uut (
    .clk(clk), .rst(rst), .cken_n(cken_n), .adv_ld(adv_ld), .rw(rw),
    .sel1_n(sel1_n), .sel2(sel2), .sel3_n(sel3_n), .bw_n(bw_n), .addr(addr),
    .lin_order(lin_order), .oe_n(oe_n), .wdata(wdata), .rdata(rdata), .rdrive(rdrive)
  );

  function automatic logic [35:0] bd(input int k);
    return 36'h0A5A5A500 + 36'(k);
  endfunction

  function automatic logic [35:0] merge(input logic [35:0] old_w, input logic [35:0] new_w,
                                        input logic [3:0] bn);
    logic [35:0] r = old_w;
    for (int i = 0; i < 4; i++)
      if (!bn[i]) r[i*9 +: 9] = new_w[i*9 +: 9];
    return r;
  endfunction

  task automatic chk(input logic [35:0] act, input logic [35:0] exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic set_sel(input logic [2:0] s);
    sel1_n = ~s[0];
    sel2   = s[1];
    sel3_n = ~s[2];
  endtask

  // one enabled cycle: drive a command, then check the command from two cycles back
  task automatic cyc(input logic adv, input logic [2:0] s, input logic r, input logic [7:0] a,
                     input logic [3:0] bn, input logic [35:0] wd,
                     input logic xr, input logic [35:0] xd, input string tag);
    cken_n = 1'b0;
    adv_ld = adv;
    set_sel(s);
    rw     = r;
    addr   = a;
    bw_n   = bn;
    wdata  = wd_p[1];
    wd_p[1] = wd_p[0];
    wd_p[0] = wd;
    @(negedge clk);
    chk({35'b0, rdrive}, {35'b0, xr_p[1]}, tg_p[1]);
    if (xr_p[1]) chk(rdata, xd_p[1], tg_p[1]);
    xr_p[1] = xr_p[0]; xd_p[1] = xd_p[0]; tg_p[1] = tg_p[0];
    xr_p[0] = xr;      xd_p[0] = xd;      tg_p[0] = tag;
  endtask

  task automatic idle(input string tag);
    cyc(1'b0, 3'b000, 1'b1, 8'h00, 4'hF, 36'h0, 1'b0, 36'h0, tag);
  endtask

  task automatic t_reset;
    chk({35'b0, rdrive}, 36'h0, "R10");
    chk(rdata, 36'h0, "R10");
    cyc(1'b1, 3'b111, 1'b1, 8'h05, 4'hF, 36'h0, 1'b0, 36'h0, "R9");
    cyc(1'b1, 3'b111, 1'b0, 8'h05, 4'h0, 36'h0, 1'b0, 36'h0, "R9");
    idle("R9");
    idle("R9");
  endtask

  task automatic t_turnaround;
    cyc(1'b0, 3'b111, 1'b0, 8'h05, 4'h0, D1, 1'b0, 36'h0, "R6");
    cyc(1'b0, 3'b111, 1'b1, 8'h05, 4'hF, 36'h0, 1'b1, D1, "R2");
    cyc(1'b0, 3'b111, 1'b0, 8'h06, 4'h0, D2, 1'b0, 36'h0, "R6");
    cyc(1'b0, 3'b111, 1'b1, 8'h06, 4'hF, 36'h0, 1'b1, D2, "R2");
    cyc(1'b0, 3'b111, 1'b1, 8'h05, 4'hF, 36'h0, 1'b1, D1, "R1");
    cyc(1'b0, 3'b111, 1'b0, 8'h05, 4'h0, D3, 1'b0, 36'h0, "R6");
    cyc(1'b0, 3'b111, 1'b1, 8'h05, 4'hF, 36'h0, 1'b1, D3, "R2");
    idle("R6");
    idle("R6");
  endtask

  task automatic t_bytes;
    cyc(1'b0, 3'b111, 1'b0, 8'h07, 4'h0, P7, 1'b0, 36'h0, "R3");
    cyc(1'b0, 3'b111, 1'b0, 8'h07, 4'b1010, N7, 1'b0, 36'h0, "R3");
    cyc(1'b0, 3'b111, 1'b1, 8'h07, 4'hF, 36'h0, 1'b1, merge(P7, N7, 4'b1010), "R3");
    idle("R3");
    idle("R3");
  endtask

  task automatic t_burst;
    lin_order = 1'b1;
    cyc(1'b0, 3'b111, 1'b0, 8'h12, 4'h0, bd(2), 1'b0, 36'h0, "R8");
    lin_order = 1'b0;
    cyc(1'b1, 3'b000, 1'b1, 8'hFF, 4'h0, bd(3), 1'b0, 36'h0, "R8");
    cyc(1'b1, 3'b000, 1'b1, 8'hFF, 4'h0, bd(0), 1'b0, 36'h0, "R8");
    cyc(1'b1, 3'b000, 1'b1, 8'hFF, 4'h0, bd(1), 1'b0, 36'h0, "R8");
    idle("R8");
    idle("R8");
    for (int k = 0; k < 4; k++)
      cyc(1'b0, 3'b111, 1'b1, 8'h10 + 8'(k), 4'hF, 36'h0, 1'b1, bd(k), "R8");
    lin_order = 1'b0;
    cyc(1'b0, 3'b111, 1'b1, 8'h13, 4'hF, 36'h0, 1'b1, bd(3), "R8");
    lin_order = 1'b1;
    cyc(1'b1, 3'b000, 1'b0, 8'h00, 4'h0, 36'h0, 1'b1, bd(2), "R8");
    cyc(1'b1, 3'b000, 1'b0, 8'h00, 4'h0, 36'h0, 1'b1, bd(1), "R8");
    cyc(1'b1, 3'b000, 1'b0, 8'h00, 4'h0, 36'h0, 1'b1, bd(0), "R8");
    cyc(1'b1, 3'b000, 1'b0, 8'h00, 4'h0, 36'h0, 1'b1, bd(3), "R8");
    idle("R8");
    idle("R8");
  endtask

  task automatic t_deselect;
    lin_order = 1'b1;
    cyc(1'b0, 3'b111, 1'b1, 8'h10, 4'hF, 36'h0, 1'b1, bd(0), "R5");
    cyc(1'b1, 3'b111, 1'b1, 8'h00, 4'hF, 36'h0, 1'b1, bd(1), "R5");
    cyc(1'b0, 3'b011, 1'b1, 8'h10, 4'hF, 36'h0, 1'b0, 36'h0, "R5");
    cyc(1'b1, 3'b111, 1'b1, 8'h10, 4'hF, 36'h0, 1'b0, 36'h0, "R9");
    cyc(1'b0, 3'b110, 1'b1, 8'h10, 4'hF, 36'h0, 1'b0, 36'h0, "R5");
    cyc(1'b0, 3'b101, 1'b1, 8'h10, 4'hF, 36'h0, 1'b0, 36'h0, "R5");
    cyc(1'b0, 3'b011, 1'b0, 8'h10, 4'h0, 36'hFFFFFFFFF, 1'b0, 36'h0, "R5");
    idle("R5");
    cyc(1'b0, 3'b111, 1'b1, 8'h10, 4'hF, 36'h0, 1'b1, bd(0), "R5");
    idle("R5");
    idle("R5");
  endtask

  task automatic t_freeze;
    cken_n = 1'b0; adv_ld = 1'b0; set_sel(3'b111); rw = 1'b1; addr = 8'h05; bw_n = 4'hF;
    @(negedge clk);
    cken_n = 1'b1; rw = 1'b0; bw_n = 4'h0; wdata = 36'hBADBADBAD; addr = 8'h05;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk({35'b0, rdrive}, 36'h0, "R4");
    end
    cken_n = 1'b0; set_sel(3'b000);
    @(negedge clk);
    chk({35'b0, rdrive}, 36'h0, "R4");
    @(negedge clk);
    chk({35'b0, rdrive}, 36'h1, "R4");
    chk(rdata, D3, "R4");
    cken_n = 1'b1; set_sel(3'b111); rw = 1'b1; addr = 8'h06;
    for (int i = 0; i < 2; i++) begin
      @(negedge clk);
      chk({35'b0, rdrive}, 36'h1, "R4");
      chk(rdata, D3, "R4");
    end
    idle("R4");
    idle("R4");
    cyc(1'b0, 3'b111, 1'b1, 8'h05, 4'hF, 36'h0, 1'b1, D3, "R4");
    idle("R4");
    idle("R4");
  endtask

  task automatic t_oe;
    cyc(1'b0, 3'b111, 1'b1, 8'h06, 4'hF, 36'h0, 1'b1, D2, "R7");
    idle("R7");
    idle("R7");
    oe_n = 1'b1;
    #1;
    chk({35'b0, rdrive}, 36'h0, "R7");
    oe_n = 1'b0;
    #1;
    chk({35'b0, rdrive}, 36'h1, "R7");
    idle("R7");
  endtask

  initial begin
    for (int i = 0; i < 2; i++) begin
      wd_p[i] = '0; xr_p[i] = 1'b0; xd_p[i] = '0; tg_p[i] = "R10";
    end
    rst = 1'b1; cken_n = 1'b0; adv_ld = 1'b0; rw = 1'b1; set_sel(3'b000);
    bw_n = 4'hF; addr = '0; lin_order = 1'b1; oe_n = 1'b0; wdata = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_turnaround();
    t_bytes();
    t_burst();
    t_deselect();
    t_freeze();
    t_oe();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog (R1): actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule